// File: doc/BRIEF.md
# Power Domain Shutdown Sequencer

This block powers down one gated domain, for example a processor core, out of a small group of domains. A single start pulse, together with a domain select, launches a fixed chain of control-bit changes on that domain's power-control word. The first step is an enable strobe that carries a keyed configuration word. Three isolation steps follow. Next comes a cache power-down handshake. Reset assertion, clock gating and the removal of the two switch stages come last. The block then waits until both copies of the domain's power status read off, and it reports completion with a one-cycle pulse.

Every step changes exactly one bit and occupies a clock cycle of its own, so downstream logic and the environment see each change separately. The switch fabric outside the block returns the acknowledge and the two status vectors. The block waits on them for as long as they take.

Top module: `pwr_dn_seq`

## Requirements
- R1: After reset every domain's control field reads 0x4D: bit 0 reset-release = 1, bit 1 isolate = 0, bit 2 main switch = 1, bit 3 second switch = 1, bit 4 clock gate = 0, bit 5 memory clock isolate = 0, bit 6 memory isolate (active low) = 1. Cache requests, `busy_o`, `done_o` and `cfg_wr_o` are all 0.
- R2: After the enable strobe, the selected field first sets bit 1, then sets bit 5, then clears bit 6, in that order and in separate cycles (0x4D, 0x4F, 0x6F, 0x2F).
- R3: The selected domain's cache power-down request rises only after all three isolation steps are complete.
- R4: Only once the cache acknowledge is high, the field clears bit 0, then sets bit 4, then clears bit 2, then clears bit 3 (0x2E, 0x3E, 0x3A, 0x32).
- R5: Completion is reported only when the domain's bit is 0 in both the primary and the secondary status vectors.
- R6: Select value n (1..3) drives field n-1 (bits 7*(n-1) to 7*(n-1)+6 of `pwr_ctl_o`), request and acknowledge bit n-1, and status bit 9+n. The other domains are left unchanged.
- R7: Before the first control change, `cfg_wr_o` pulses for one cycle, and `cfg_data_o` then holds the key 0xA5C3 in bits 31:16 and a 1 in bit 0, with all other bits 0.
- R8: No more than one control bit across all fields changes in any cycle.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` is high, where it is low.
- R10: `done_o` is a single-cycle pulse in the cycle after the one in which both status bits are first seen at 0.
- R11: A start with select value 0 is dropped: no strobe, no control change, and `busy_o` stays low.
- R12: A start that arrives while a sequence is running is ignored. The running sequence completes, and the other domain is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| sel_i | input | 2 | Domain select, 1..3 valid |
| pdn_ack_i | input | 3 | Cache power-down acknowledge, one per domain |
| pwr_sta_i | input | 32 | Primary power-status vector |
| pwr_sta2_i | input | 32 | Secondary power-status vector |
| pwr_ctl_o | output | 21 | Three 7-bit power-control fields |
| pdn_req_o | output | 3 | Cache power-down request, one per domain |
| cfg_wr_o | output | 1 | Control-enable strobe |
| cfg_data_o | output | 32 | Keyed control-enable word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Shutdown complete pulse |

## Verification
The hardest case to reach is the completion condition when the two status copies fall at different times, since completion must wait for the later one. The stimulus gets there with an environment model that drops each status copy after its own random delay, counted from the clearing of the matching switch bit. One directed case holds the secondary copy high for thirty cycles after the primary has fallen. Further cases set the acknowledge before the request is raised, inject a second start in the middle of a sequence, and use an invalid select.

// File: rtl/pwr_dn_pkg.sv
package pwr_dn_pkg;
    localparam int CW      = 7;
    localparam int B_RSTN  = 0;
    localparam int B_ISO   = 1;
    localparam int B_ON    = 2;
    localparam int B_ON2   = 3;
    localparam int B_CKD   = 4;
    localparam int B_SCKI  = 5;
    localparam int B_SISOB = 6;
    localparam logic [CW-1:0] CTL_RUN = 7'b100_1101;

    typedef enum logic [3:0] {
        S_IDLE, S_CFG, S_ISO, S_CKISO, S_SRISO, S_PDN, S_WACK,
        S_RST, S_CLKD, S_ON, S_ON2, S_WOFF
    } seq_st_e;

    typedef enum logic [3:0] {
        OP_NONE, OP_ISO, OP_CKISO, OP_SRISO, OP_PDN,
        OP_RST, OP_CLKD, OP_ON, OP_ON2
    } step_op_e;
endpackage

// File: rtl/pwr_dn_decode.sv
module pwr_dn_decode
    import pwr_dn_pkg::*;
#(
    parameter int NUM_DOM  = 3,
    parameter int SEL_W    = 2,
    parameter int STA_W    = 32,
    parameter int STA_BASE = 10
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [SEL_W-1:0]   dom_i,
    input  logic [NUM_DOM-1:0] ack_vec_i,
    input  logic [STA_W-1:0]   sta_i,
    input  logic [STA_W-1:0]   sta2_i,
    output logic               sel_ok_o,
    output logic [NUM_DOM-1:0] dom_oh_o,
    output logic               ack_o,
    output logic               off_o
);
    logic [NUM_DOM-1:0] sta_sub, sta2_sub;

    assign sel_ok_o = (sel_i != '0) && (sel_i <= SEL_W'(NUM_DOM));

    genvar g;
    generate
        for (g = 0; g < NUM_DOM; g++) begin : g_dom
            assign dom_oh_o[g] = (dom_i == SEL_W'(g + 1));
            assign sta_sub[g]  = sta_i[STA_BASE + g];
            assign sta2_sub[g] = sta2_i[STA_BASE + g];
        end
    endgenerate

    assign ack_o = |(dom_oh_o & ack_vec_i);
    assign off_o = (|dom_oh_o) && ((dom_oh_o & (sta_sub | sta2_sub)) == '0);

    wire unused_sta = ^{sta_i, sta2_i};
endmodule

// File: rtl/pwr_dn_fsm.sv
module pwr_dn_fsm
    import pwr_dn_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             sel_ok_i,
    input  logic             ack_i,
    input  logic             off_i,
    output logic [SEL_W-1:0] dom_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             cfg_wr_o,
    output step_op_e         op_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [SEL_W-1:0] dom;
        logic             busy;
        logic             done;
        logic             cfg_wr;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.cfg_wr = 1'b0;
        op_o       = OP_NONE;
        case (r_q.st)
            S_IDLE: if (start_i && sel_ok_i) begin
                r_d.st   = S_CFG;
                r_d.dom  = sel_i;
                r_d.busy = 1'b1;
            end
            S_CFG:   begin r_d.cfg_wr = 1'b1; r_d.st = S_ISO; end
            S_ISO:   begin op_o = OP_ISO;   r_d.st = S_CKISO; end
            S_CKISO: begin op_o = OP_CKISO; r_d.st = S_SRISO; end
            S_SRISO: begin op_o = OP_SRISO; r_d.st = S_PDN; end
            S_PDN:   begin op_o = OP_PDN;   r_d.st = S_WACK; end
            S_WACK:  if (ack_i) r_d.st = S_RST;
            S_RST:   begin op_o = OP_RST;   r_d.st = S_CLKD; end
            S_CLKD:  begin op_o = OP_CLKD;  r_d.st = S_ON; end
            S_ON:    begin op_o = OP_ON;    r_d.st = S_ON2; end
            S_ON2:   begin op_o = OP_ON2;   r_d.st = S_WOFF; end
            S_WOFF:  if (off_i) begin
                r_d.done = 1'b1;
                r_d.busy = 1'b0;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, dom: '0, busy: 1'b0, done: 1'b0, cfg_wr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dom_o    = r_q.dom;
    assign busy_o   = r_q.busy;
    assign done_o   = r_q.done;
    assign cfg_wr_o = r_q.cfg_wr;
endmodule

// File: rtl/pwr_dn_bank.sv
module pwr_dn_bank
    import pwr_dn_pkg::*;
#(
    parameter int NUM_DOM = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  step_op_e              op_i,
    input  logic [NUM_DOM-1:0]    dom_oh_i,
    output logic [NUM_DOM*CW-1:0] ctl_o,
    output logic [NUM_DOM-1:0]    pdn_o
);
    genvar g;
    generate
        for (g = 0; g < NUM_DOM; g++) begin : g_fld
            logic [CW-1:0] ctl_d, ctl_q;
            logic          pdn_d, pdn_q;

            always_comb begin
                ctl_d = ctl_q;
                pdn_d = pdn_q;
                if (dom_oh_i[g]) begin
                    case (op_i)
                        OP_ISO:   ctl_d[B_ISO]   = 1'b1;
                        OP_CKISO: ctl_d[B_SCKI]  = 1'b1;
                        OP_SRISO: ctl_d[B_SISOB] = 1'b0;
                        OP_PDN:   pdn_d          = 1'b1;
                        OP_RST:   ctl_d[B_RSTN]  = 1'b0;
                        OP_CLKD:  ctl_d[B_CKD]   = 1'b1;
                        OP_ON:    ctl_d[B_ON]    = 1'b0;
                        OP_ON2:   ctl_d[B_ON2]   = 1'b0;
                        default:  ;
                    endcase
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctl_q <= CTL_RUN;
                    pdn_q <= 1'b0;
                end else begin
                    ctl_q <= ctl_d;
                    pdn_q <= pdn_d;
                end
            end

            assign ctl_o[g*CW +: CW] = ctl_q;
            assign pdn_o[g]          = pdn_q;
        end
    endgenerate
endmodule

// File: rtl/pwr_dn_seq.sv
module pwr_dn_seq
    import pwr_dn_pkg::*;
#(
    parameter int          NUM_DOM  = 3,
    parameter int          STA_W    = 32,
    parameter int          STA_BASE = 10,
    parameter int          CFG_W    = 32,
    parameter logic [15:0] CFG_KEY  = 16'hA5C3,
    localparam int         SEL_W    = $clog2(NUM_DOM + 1),
    localparam int         CTL_W    = NUM_DOM * CW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_DOM-1:0] pdn_ack_i,
    input  logic [STA_W-1:0]   pwr_sta_i,
    input  logic [STA_W-1:0]   pwr_sta2_i,
    output logic [CTL_W-1:0]   pwr_ctl_o,
    output logic [NUM_DOM-1:0] pdn_req_o,
    output logic               cfg_wr_o,
    output logic [CFG_W-1:0]   cfg_data_o,
    output logic               busy_o,
    output logic               done_o
);
    logic               sel_ok, ack_sel, off_sel;
    logic [SEL_W-1:0]   dom_q;
    logic [NUM_DOM-1:0] dom_oh;
    step_op_e           op;

    assign cfg_data_o = {CFG_KEY, {(CFG_W - 17){1'b0}}, 1'b1};

    pwr_dn_decode #(
        .NUM_DOM(NUM_DOM), .SEL_W(SEL_W), .STA_W(STA_W), .STA_BASE(STA_BASE)
    ) i_decode (
        .sel_i(sel_i), .dom_i(dom_q), .ack_vec_i(pdn_ack_i),
        .sta_i(pwr_sta_i), .sta2_i(pwr_sta2_i),
        .sel_ok_o(sel_ok), .dom_oh_o(dom_oh), .ack_o(ack_sel), .off_o(off_sel)
    );

    pwr_dn_fsm #(.SEL_W(SEL_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .sel_ok_i(sel_ok), .ack_i(ack_sel), .off_i(off_sel),
        .dom_o(dom_q), .busy_o(busy_o), .done_o(done_o),
        .cfg_wr_o(cfg_wr_o), .op_o(op)
    );

    pwr_dn_bank #(.NUM_DOM(NUM_DOM)) i_bank (
        .clk(clk), .rst_n(rst_n), .op_i(op), .dom_oh_i(dom_oh),
        .ctl_o(pwr_ctl_o), .pdn_o(pdn_req_o)
    );
endmodule

// File: rtl/pwr_dn_chk.sv
module pwr_dn_chk
    import pwr_dn_pkg::*;
#(
    parameter int NUM_DOM  = 3,
    parameter int SEL_W    = 2,
    parameter int STA_W    = 32,
    parameter int STA_BASE = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [SEL_W-1:0]      sel_i,
    input logic [SEL_W-1:0]      dom_q,
    input logic [STA_W-1:0]      pwr_sta_i,
    input logic [STA_W-1:0]      pwr_sta2_i,
    input logic [NUM_DOM*CW-1:0] pwr_ctl_o,
    input logic [NUM_DOM-1:0]    pdn_req_o,
    input logic                  busy_o,
    input logic                  done_o
);
    logic [STA_W-1:0] dom_mask;
    logic             sel_bad;
    assign dom_mask = (dom_q == '0) ? '0 : (STA_W'(1) << (STA_BASE + int'(dom_q) - 1));
    assign sel_bad  = (sel_i == '0) || (sel_i > SEL_W'(NUM_DOM));

    a_r5_done_needs_off: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (($past(pwr_sta_i | pwr_sta2_i) & dom_mask) == '0));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r8_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwr_ctl_o ^ $past(pwr_ctl_o)) <= 1);

    a_r11_bad_sel_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && sel_bad) |=> !busy_o);

    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(dom_q));

    genvar g;
    generate
        for (g = 0; g < NUM_DOM; g++) begin : g_dom
            a_r2_iso_before_release: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pwr_ctl_o[g*CW + B_SISOB]) |->
                    (pwr_ctl_o[g*CW + B_ISO] && pwr_ctl_o[g*CW + B_SCKI]));
            a_r4_reset_after_request: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pwr_ctl_o[g*CW + B_RSTN]) |-> pdn_req_o[g]);
            a_r3_request_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pdn_req_o[g]) |-> !pwr_ctl_o[g*CW + B_SISOB]);
        end
    endgenerate
endmodule

bind pwr_dn_seq pwr_dn_chk #(
    .NUM_DOM(NUM_DOM), .SEL_W(SEL_W), .STA_W(STA_W), .STA_BASE(STA_BASE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i), .dom_q(dom_q),
    .pwr_sta_i(pwr_sta_i), .pwr_sta2_i(pwr_sta2_i), .pwr_ctl_o(pwr_ctl_o),
    .pdn_req_o(pdn_req_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_pwr_dn_seq.sv
module test_pwr_dn_seq;
    localparam int ND = 3;
    localparam int SB = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  sel_i = '0;
    logic [2:0]  pdn_ack_i = '0;
    logic [31:0] pwr_sta_i = '0;
    logic [31:0] pwr_sta2_i = '0;
    logic [20:0] pwr_ctl_o;
    logic [2:0]  pdn_req_o;
    logic        cfg_wr_o;
    logic [31:0] cfg_data_o;
    logic        busy_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;

    always #10 clk = ~clk;

    pwr_dn_seq i_pwr_dn_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .pdn_ack_i(pdn_ack_i), .pwr_sta_i(pwr_sta_i), .pwr_sta2_i(pwr_sta2_i),
        .pwr_ctl_o(pwr_ctl_o), .pdn_req_o(pdn_req_o), .cfg_wr_o(cfg_wr_o),
        .cfg_data_o(cfg_data_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [6:0] fld(input logic [20:0] v, input int d);
        return v[(d-1)*7 +: 7];
    endfunction

    function automatic logic [6:0] exp_step(input int k);
        case (k)
            0: return 7'h4F; 1: return 7'h6F; 2: return 7'h2F;
            3: return 7'h2E; 4: return 7'h3E; 5: return 7'h3A;
            default: return 7'h32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        sel_i = '0;
        pdn_ack_i = '0;
        pwr_sta_i = $urandom | (32'h7 << SB);
        pwr_sta2_i = $urandom | (32'h7 << SB);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pwr_ctl_o == {3{7'h4D}}, "R1 ctl", 32'(pwr_ctl_o), 32'({3{7'h4D}}));
        chk(pdn_req_o == '0 && !busy_o && !done_o && !cfg_wr_o, "R1 flags",
            {pdn_req_o, busy_o, done_o, cfg_wr_o}, 0);
    endtask

    task automatic trial(input int dom, input int ack_dly, input int d1, input int d2,
                         input bit early_ack, input bit poke);
        int k = 0, acnt = -1, c1 = -1, c2 = -1, both_at = -1, cyc = 0;
        int other;
        bit got_done = 0, cfg_seen = 0;
        logic [6:0] prev = 7'h4D, cur;
        logic pdn_prev = 1'b0;
        other = (dom % 3) + 1;
        do_reset();
        if (early_ack) pdn_ack_i[dom-1] = 1'b1;
        start_i = 1'b1;
        sel_i = 2'(dom);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
        while (!got_done && cyc < 500) begin
            cur = fld(pwr_ctl_o, dom);
            if (cfg_wr_o) begin
                chk(cfg_data_o == 32'hA5C3_0001 && k == 0 && !cfg_seen, "R7 strobe",
                    cfg_data_o, 32'hA5C3_0001);
                cfg_seen = 1;
            end
            if (cur != prev) begin
                chk(cur == exp_step(k), (k < 3) ? "R2 step" : "R4 step", cur, exp_step(k));
                if (k == 0) chk(cfg_seen, "R7 strobe before steps", cfg_seen, 1);
                if (k >= 3) chk(pdn_req_o[dom-1] && pdn_ack_i[dom-1], "R4 after ack",
                                {pdn_req_o[dom-1], pdn_ack_i[dom-1]}, 3);
                k++;
                prev = cur;
            end
            if (pdn_req_o[dom-1] && !pdn_prev) chk(k == 3, "R3 request order", k, 3);
            pdn_prev = pdn_req_o[dom-1];
            chk(fld(pwr_ctl_o, other) == 7'h4D && !pdn_req_o[other-1], "R6 R12 other untouched",
                fld(pwr_ctl_o, other), 7'h4D);
            if (done_o) begin
                chk(k == 7 && both_at >= 0 && cyc == both_at + 1, "R5 R10 done timing",
                    cyc, both_at + 1);
                chk(!busy_o, "R9 busy low at done", busy_o, 0);
                got_done = 1;
            end else begin
                chk(busy_o, "R9 busy held", busy_o, 1);
            end
            // environment model: acknowledge and status drops
            if (pdn_req_o[dom-1] && !pdn_ack_i[dom-1]) begin
                if (acnt < 0) acnt = ack_dly;
                if (acnt == 0) pdn_ack_i[dom-1] = 1'b1; else acnt--;
            end
            if (!cur[2] && pwr_sta_i[SB+dom-1]) begin
                if (c1 < 0) c1 = d1;
                if (c1 == 0) pwr_sta_i[SB+dom-1] = 1'b0; else c1--;
            end
            if (!cur[3] && pwr_sta2_i[SB+dom-1]) begin
                if (c2 < 0) c2 = d2;
                if (c2 == 0) pwr_sta2_i[SB+dom-1] = 1'b0; else c2--;
            end
            if (both_at < 0 && !pwr_sta_i[SB+dom-1] && !pwr_sta2_i[SB+dom-1]) both_at = cyc;
            if (poke && cyc == 4) begin start_i = 1'b1; sel_i = 2'(other); end
            if (poke && cyc == 5) start_i = 1'b0;
            if (!got_done) begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(got_done, "R5 completion reached", got_done, 1);
        @(negedge clk);
        chk(!done_o && !busy_o, "R10 single pulse", {done_o, busy_o}, 0);
        chk(fld(pwr_ctl_o, dom) == 7'h32, "R4 final field", fld(pwr_ctl_o, dom), 7'h32);
    endtask

    task automatic bad_sel();
        do_reset();
        start_i = 1'b1;
        sel_i = 2'd0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            chk(!busy_o && !cfg_wr_o && pwr_ctl_o == {3{7'h4D}} && pdn_req_o == '0,
                "R11 invalid select", {busy_o, cfg_wr_o, pdn_req_o}, 0);
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        trial(1, 0, 0, 0, 1'b1, 1'b0);   // acknowledge already high
        trial(2, 3, 0, 30, 1'b0, 1'b0);  // secondary copy late (R5)
        trial(3, 2, 5, 1, 1'b0, 1'b1);   // start during sequence (R12)
        bad_sel();
        for (int t = 0; t < 8; t++) begin
            trial($urandom_range(3, 1), $urandom_range(12, 0), $urandom_range(12, 0),
                  $urandom_range(12, 0), 1'b0, t[0]);
        end
        bad_sel();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule